// File: doc/BRIEF.md
# Threshold-Gated Interrupt Pending Register

This block collects interrupt requests into a bitmap that holds one pending bit for each of 256 vectors. Each vector falls into a priority class given by its upper four bits. A four-bit threshold register can be written at any time. The block picks the highest pending vector whose class is strictly above the threshold and presents it to the processor side as a ready flag together with the vector number.

The processor takes the presented vector by pulsing an acknowledge input, and that clears the vector's pending bit. Vectors whose class does not clear the threshold stay pending for as long as needed. They come out without any new request once the threshold is lowered. A second request for a vector that is already pending adds nothing. Vectors 0 to 15 are reserved for exceptions, and requests on them are dropped. Vectors 16 to 31 behave like any other interrupt.

Top module: `ptpr_top`

## Requirements
- R1: A synchronous active-high reset clears every pending bit, sets the threshold to 0 and drives `irq_ready` low.
- R2: A request (`req_valid` high) on a vector of 16 or above sets that vector's pending bit. Further requests for a vector that is already pending merge into the same bit, so one acknowledge removes all of them.
- R3: Requests on vectors 0 to 15 are ignored and never make `irq_ready` rise.
- R4: A pending vector is presented only when its class (vector bits 7:4) is strictly greater than the threshold. Otherwise it stays pending.
- R5: A threshold of 15 blocks every vector. A threshold of 0 passes every class from 1 to 15.
- R6: When several pending vectors are eligible, `irq_vec` shows the numerically highest of them.
- R7: Lowering the threshold releases vectors that were held pending, with no new request.
- R8: `ack` while `irq_ready` is high clears the pending bit of the vector on `irq_vec`. `ack` while `irq_ready` is low has no effect.
- R9: A request for the presented vector in the same cycle as its acknowledge leaves that vector pending.
- R10: `irq_ready` and `irq_vec` are registered. They change one clock after the edge that updated the pending bits or the threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one vector per cycle |
| req_vec | input | 8 | Vector number of the request |
| tpr_we | input | 1 | Threshold write enable |
| tpr_wdata | input | 4 | New threshold value |
| ack | input | 1 | Processor takes the presented vector |
| irq_ready | output | 1 | An eligible vector is presented |
| irq_vec | output | 8 | Presented vector number |

## Verification
The hardest state to reach is a vector that sits pending behind the threshold and is later released when the threshold is lowered. The threshold must be written above the vector's class before the request arrives, and no acknowledge may reach that vector while it is held. The bench sweeps every threshold from 0 to 15 against every interrupt vector. Each vector that ends up held is then released by writing 0 to the threshold, and the bench checks that it comes out.

Merged requests, an acknowledge while nothing is ready, and an acknowledge that collides with a new request for the same vector are each set up directly at the ports.

// File: rtl/ptpr_pkg.sv
package ptpr_pkg;

    localparam int VEC_W        = 8;
    localparam int CLS_W        = 4;
    localparam int SUB_W        = VEC_W - CLS_W;
    localparam int NUM_VEC      = 1 << VEC_W;
    localparam int NUM_CLS      = 1 << CLS_W;
    localparam int GRP          = 1 << SUB_W;
    localparam int IGNORE_BELOW = 16;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [CLS_W-1:0] cls_t;
    typedef logic [SUB_W-1:0] sub_t;

    // candidate handed to the processor side
    typedef struct packed {
        logic valid;
        vec_t vec;
    } pick_t;

    // index of the most significant set bit in one class group
    function automatic sub_t top_index(input logic [GRP-1:0] b);
        sub_t r;
        r = '0;
        for (int i = 0; i < GRP; i++) begin
            if (b[i]) r = sub_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/ptpr_pending.sv
module ptpr_pending
    import ptpr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  vec_t               set_vec,
    input  logic               clr_en,
    input  vec_t               clr_vec,
    output logic [NUM_VEC-1:0] pend
);

    generate
        for (genvar i = 0; i < NUM_VEC; i++) begin : g_bit
            if (i < IGNORE_BELOW) begin : g_off
                assign pend[i] = 1'b0;
            end else begin : g_on
                logic q;
                logic hit_set;
                logic hit_clr;
                assign hit_set = set_en && (set_vec == vec_t'(i));
                assign hit_clr = clr_en && (clr_vec == vec_t'(i));
                always_ff @(posedge clk) begin
                    if (rst)          q <= 1'b0;
                    else if (hit_set) q <= 1'b1;
                    else if (hit_clr) q <= 1'b0;
                end
                assign pend[i] = q;
            end
        end
    endgenerate

endmodule

// File: rtl/ptpr_tpr.sv
module ptpr_tpr
    import ptpr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  cls_t wdata,
    output cls_t level
);

    always_ff @(posedge clk) begin
        if (rst)     level <= '0;
        else if (we) level <= wdata;
    end

endmodule

// File: rtl/ptpr_select.sv
module ptpr_select
    import ptpr_pkg::*;
(
    input  logic [NUM_VEC-1:0] pend,
    input  cls_t               level,
    output pick_t              pick
);

    logic [NUM_CLS-1:0] cls_ok;
    sub_t               cls_idx [NUM_CLS];

    generate
        for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
            logic [GRP-1:0] slice;
            assign slice      = pend[c*GRP +: GRP];
            assign cls_ok[c]  = (|slice) && (cls_t'(c) > level);
            assign cls_idx[c] = top_index(slice);
        end
    endgenerate

    // highest eligible class wins, then highest vector inside it
    always_comb begin
        pick = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (cls_ok[c]) begin
                pick.valid = 1'b1;
                pick.vec   = {cls_t'(c), cls_idx[c]};
            end
        end
    end

endmodule

// File: rtl/ptpr_top.sv
module ptpr_top
    import ptpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vec,
    input  logic             tpr_we,
    input  logic [CLS_W-1:0] tpr_wdata,
    input  logic             ack,
    output logic             irq_ready,
    output logic [VEC_W-1:0] irq_vec
);

    cls_t               tpr_level;
    logic [NUM_VEC-1:0] pend;
    pick_t              pick;
    pick_t              out_q;
    logic               clr_en;

    assign clr_en = ack && out_q.valid;

    ptpr_tpr u_tpr (
        .clk   (clk),
        .rst   (rst),
        .we    (tpr_we),
        .wdata (tpr_wdata),
        .level (tpr_level)
    );

    ptpr_pending u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_en  (req_valid),
        .set_vec (req_vec),
        .clr_en  (clr_en),
        .clr_vec (out_q.vec),
        .pend    (pend)
    );

    ptpr_select u_sel (
        .pend  (pend),
        .level (tpr_level),
        .pick  (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= pick;
    end

    assign irq_ready = out_q.valid;
    assign irq_vec   = out_q.vec;

endmodule

// File: rtl/ptpr_chk.sv
module ptpr_chk
    import ptpr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [VEC_W-1:0]   req_vec,
    input logic               ack,
    input logic               irq_ready,
    input logic [VEC_W-1:0]   irq_vec,
    input logic [CLS_W-1:0]   tpr_level,
    input logic [NUM_VEC-1:0] pend
);

    cls_t tpr_d;
    always_ff @(posedge clk) begin
        if (rst) tpr_d <= '0;
        else     tpr_d <= tpr_level;
    end

    // R4
    ready_above_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ready |-> (irq_vec[VEC_W-1 -: CLS_W] > tpr_d));

    // R3
    ready_range_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ready |-> (irq_vec >= vec_t'(IGNORE_BELOW)));

    // R5
    block_all_chk: assert property (@(posedge clk) disable iff (rst)
        (tpr_level == cls_t'(NUM_CLS-1)) |=> !irq_ready);

    // R2
    req_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_vec >= vec_t'(IGNORE_BELOW)) |=> pend[$past(req_vec)]);

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_ready && !(req_valid && req_vec == irq_vec)) |=> !pend[$past(irq_vec)]);

    // R9
    ack_req_same_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_ready && req_valid && req_vec == irq_vec) |=> pend[$past(irq_vec)]);

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |=> !irq_ready);

endmodule

bind ptpr_top ptpr_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_vec   (req_vec),
    .ack       (ack),
    .irq_ready (irq_ready),
    .irq_vec   (irq_vec),
    .tpr_level (tpr_level),
    .pend      (pend)
);

// File: tb/ptpr_top_tb_top.sv
module ptpr_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [7:0] req_vec = '0;
    logic       tpr_we = 1'b0;
    logic [3:0] tpr_wdata = '0;
    logic       ack = 1'b0;
    logic       irq_ready;
    logic [7:0] irq_vec;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ptpr_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_vec   (req_vec),
        .tpr_we    (tpr_we),
        .tpr_wdata (tpr_wdata),
        .ack       (ack),
        .irq_ready (irq_ready),
        .irq_vec   (irq_vec)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_req(input int v);
        req_valid = 1'b1;
        req_vec   = 8'(v);
        cyc();
        req_valid = 1'b0;
    endtask

    task automatic do_tpr(input int t);
        tpr_we    = 1'b1;
        tpr_wdata = 4'(t);
        cyc();
        tpr_we    = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        cyc();
        ack = 1'b0;
    endtask

    // expects a vector presented (exp_vec >= 0) or nothing (exp_vec < 0)
    task automatic expect_out(input string req, input int exp_vec);
        if (exp_vec < 0) begin
            check(irq_ready == 1'b0, req, int'(irq_ready), 0);
        end else begin
            check(irq_ready == 1'b1, req, int'(irq_ready), 1);
            check(int'(irq_vec) == exp_vec, req, int'(irq_vec), exp_vec);
        end
    endtask

    task automatic take(input string req, input int exp_vec);
        expect_out(req, exp_vec);
        do_ack();
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        expect_out("R1", -1);
        do_req(8'h20);
        // R10: pending set, output not yet updated
        expect_out("R10", -1);
        cyc();
        // R1 threshold reset to 0 lets class 2 through
        take("R1", 8'h20);
        expect_out("R8", -1);

        // R3 exception vectors ignored
        for (int v = 0; v < 16; v++) begin
            do_req(v);
            cyc();
            expect_out("R3", -1);
        end

        // R4 R5 R7 R8 sweep of threshold against every interrupt vector
        for (int t = 0; t < 16; t++) begin
            do_tpr(t);
            for (int v = 16; v < 256; v++) begin
                do_req(v);
                cyc();
                if ((v >> 4) > t) begin
                    expect_out(t == 0 ? "R5" : "R4", v);
                end else begin
                    expect_out(t == 15 ? "R5" : "R4", -1);
                    do_tpr(0);
                    cyc();
                    expect_out("R7", v);
                    do_tpr(t);
                end
                do_ack();
                cyc();
                expect_out("R8", -1);
            end
        end

        // R6 highest eligible vector first
        do_tpr(0);
        do_req(8'h35); do_req(8'h9A); do_req(8'h9F); do_req(8'h21);
        cyc();
        take("R6", 8'h9F);
        take("R6", 8'h9A);
        take("R6", 8'h35);
        take("R6", 8'h21);
        expect_out("R6", -1);

        // R6 R7 mixed with threshold 5
        do_tpr(5);
        do_req(8'h35); do_req(8'h72); do_req(8'h61);
        cyc();
        take("R6", 8'h72);
        take("R6", 8'h61);
        expect_out("R4", -1);
        do_tpr(2);
        // R10: threshold changed, output not yet updated
        expect_out("R10", -1);
        cyc();
        take("R7", 8'h35);

        // R2 merged requests
        do_tpr(0);
        do_req(8'h44); do_req(8'h44); do_req(8'h44);
        cyc();
        take("R2", 8'h44);
        expect_out("R2", -1);

        // R8 ack while nothing ready has no effect
        do_tpr(15);
        do_req(8'h80);
        cyc();
        expect_out("R5", -1);
        do_ack();
        cyc();
        do_tpr(0);
        cyc();
        take("R8", 8'h80);
        expect_out("R8", -1);

        // R9 ack colliding with a request for the same vector
        do_req(8'h50);
        cyc();
        expect_out("R9", 8'h50);
        ack = 1'b1; req_valid = 1'b1; req_vec = 8'h50;
        cyc();
        ack = 1'b0; req_valid = 1'b0;
        cyc();
        take("R9", 8'h50);
        expect_out("R9", -1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule